// File: doc/BRIEF.md
# Three-Phase Voltage Sag Detector

This block watches the peak magnitude of three line voltages and decides, one half-line cycle at a time, whether each phase sits below a programmable level. A per-phase zero-crossing strobe closes each half cycle; the most recent peak sample of that phase is then compared with the level. When a phase has spent a programmed number of consecutive half cycles on the opposite side of the level from its current state, the phase state flips. A drop below the level sets the state bit, and a return above it clears the bit. Either flip also raises one shared sticky sag status bit.

The status bit stays set until the host writes a 1 to it. An active-low interrupt follows the status bit whenever the matching mask bit is set. A small register port holds the level, the half-cycle count, the mask, the status and the read-only phase states. Writing the count register restarts every phase's half-cycle counter, so the first decision after the write always covers a full count.

Top module: `sag_monitor`

## Requirements
- R1: After reset the phase states, the status bit and the mask are 0, irq_n is 1, the level reads 0 and the half-cycle count reads 1.
- R2: Register map (address: content): 0 level in bits 23:0; 1 half-cycle count in bits 7:0; 2 mask in bit 16; 3 status in bit 16; 4 phase states in bits 14:12 (phase A bit 12, B bit 13, C bit 14). Unused bits read 0, and writes to address 4 have no effect.
- R3: A phase's zero-crossing strobe closes a half cycle. That half cycle counts as below when the phase's peak is less than the level. The peak is the sample valid in the same cycle if there is one, otherwise the last valid sample of that phase.
- R4: With count N (N ≥ 1) and state 0, the Nth consecutive below half cycle sets that phase's state bit and the status bit at the same clock edge.
- R5: With state 1, the Nth consecutive half cycle that is not below clears that phase's state bit and sets the status bit.
- R6: A half cycle on the same side as the current state restarts that phase's run, so an event needs N fresh consecutive opposite half cycles.
- R7: Writing address 3 with bit 16 set clears the status bit. A write with bit 16 clear leaves it unchanged.
- R8: An event in the same cycle as a status clear leaves the status bit set.
- R9: irq_n is 0 exactly while both the status bit and the mask bit are 1, changing in the same cycle as the status bit.
- R10: Writing address 1 restarts the half-cycle runs of all phases.
- R11: A count of 0 produces no events.
- R12: Phases are independent, and a cycle without a zero-crossing strobe changes no phase state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pk_vld | input | 3 | Per-phase peak sample valid (bit 0 = A) |
| pk_mag | input | 72 | Peak magnitudes, 24 bits per phase, A in bits 23:0 |
| zc | input | 3 | Per-phase zero-crossing strobe (bit 0 = A) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The checker watches four things on every cycle. The interrupt is never low without both status and mask set. Every event sets the status bit on the next edge. The status bit and the phase states never change without an event. A clear with no event empties the status bit. Only the bench scenarios can show the counting itself: the number of half cycles before a flip, run restarts on same-side half cycles, the count-register restart, held versus fresh peak samples, and the zero-count case.

// File: rtl/sag_pkg.sv
// Shared constants for the sag detector: widths, register addresses, bit positions.
package sag_pkg;
    localparam int NPH      = 3;
    localparam int LVL_W    = 24;
    localparam int CYC_W    = 8;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int STS_BIT  = 16;
    localparam int PH_LSB   = 12;

    localparam logic [ADDR_W-1:0] A_LEVEL = 3'd0;
    localparam logic [ADDR_W-1:0] A_NCYC  = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PHST  = 3'd4;

    localparam logic [CYC_W-1:0] NCYC_RST = 8'd1;
endpackage

// File: rtl/sag_phase_trk.sv
// Per-phase half-cycle tracker. It holds the last peak sample and classifies
// each half cycle at the zero-crossing strobe as below or not below the level.
// It counts consecutive half cycles opposite to the current state and flips
// the state after ncyc of them. Assumes ncyc == 0 means "never fire".
module sag_phase_trk #(
    parameter int LVL_W = 24,
    parameter int CYC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pk_vld,
    input  logic [LVL_W-1:0] pk_mag,
    input  logic             zc,
    input  logic [LVL_W-1:0] level,
    input  logic [CYC_W-1:0] ncyc,
    input  logic             cnt_clr,
    output logic             state,
    output logic             evt
);
    logic [LVL_W-1:0] held_q;
    logic [LVL_W-1:0] cur;
    logic [CYC_W-1:0] run_q;
    logic             below;
    logic             opp;
    logic             hit;

    // Select the peak for this cycle: a fresh sample overrides the held one.
    always_comb begin
        cur   = pk_vld ? pk_mag : held_q;
        below = cur < level;
        opp   = state ? !below : below;
        hit   = (ncyc != '0) && (({1'b0, run_q} + 1'b1) == {1'b0, ncyc});
        evt   = zc && opp && hit && !cnt_clr;
    end

    // Hold the most recent valid peak sample.
    always_ff @(posedge clk) begin
        if (!rst_n)      held_q <= '0;
        else if (pk_vld) held_q <= pk_mag;
    end

    // Run counter: restart on clear, same-side half cycle or event.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= '0;
        else if (cnt_clr) run_q <= '0;
        else if (zc) begin
            if (!opp || hit) run_q <= '0;
            else             run_q <= run_q + 1'b1;
        end
    end

    // Phase state flips on each event.
    always_ff @(posedge clk) begin
        if (!rst_n)   state <= 1'b0;
        else if (evt) state <= !state;
    end
endmodule

// File: rtl/sag_regs.sv
// Register file: level, half-cycle count, mask, sticky status, read mux.
// A status set from any phase event wins over a host write-1 clear.
// A write to the count register pulses cnt_clr to restart all runs.
module sag_regs
    import sag_pkg::*;
#(
    parameter int N = NPH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [N-1:0]      ph_state,
    input  logic              evt_any,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [LVL_W-1:0]  level,
    output logic [CYC_W-1:0]  ncyc,
    output logic              cnt_clr,
    output logic              sts,
    output logic              mask
);
    logic sts_clr;

    // Decode write strobes.
    always_comb begin
        cnt_clr = reg_wr && (reg_addr == A_NCYC);
        sts_clr = reg_wr && (reg_addr == A_STAT) && reg_wdata[STS_BIT];
    end

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            ncyc  <= NCYC_RST;
            mask  <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_LEVEL) level <= reg_wdata[LVL_W-1:0];
            if (reg_addr == A_NCYC)  ncyc  <= reg_wdata[CYC_W-1:0];
            if (reg_addr == A_MASK)  mask  <= reg_wdata[STS_BIT];
        end
    end

    // Sticky status: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       sts <= 1'b0;
        else if (evt_any) sts <= 1'b1;
        else if (sts_clr) sts <= 1'b0;
    end

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_LEVEL: reg_rdata[LVL_W-1:0]       = level;
            A_NCYC:  reg_rdata[CYC_W-1:0]       = ncyc;
            A_MASK:  reg_rdata[STS_BIT]         = mask;
            A_STAT:  reg_rdata[STS_BIT]         = sts;
            A_PHST:  reg_rdata[PH_LSB+N-1:PH_LSB] = ph_state;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sag_irq.sv
// Active-low interrupt: low while the status bit is set and unmasked.
// Combinational so it moves in the same cycle as the status bit.
module sag_irq (
    input  logic sts,
    input  logic mask,
    output logic irq_n
);
    // Drive the interrupt level.
    always_comb irq_n = !(sts && mask);
endmodule

// File: rtl/sag_monitor.sv
// Top of the three-phase sag detector: one tracker per phase, a shared
// register file with sticky status, and the interrupt output stage.
module sag_monitor
    import sag_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPH-1:0]        pk_vld,
    input  logic [NPH*LVL_W-1:0]  pk_mag,
    input  logic [NPH-1:0]        zc,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  irq_n
);
    logic [LVL_W-1:0] level;
    logic [CYC_W-1:0] ncyc;
    logic             cnt_clr;
    logic             sts_q;
    logic             mask_q;
    logic [NPH-1:0]   ph_state;
    logic [NPH-1:0]   evt;

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        sag_phase_trk #(.LVL_W(LVL_W), .CYC_W(CYC_W)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .pk_vld  (pk_vld[p]),
            .pk_mag  (pk_mag[p*LVL_W +: LVL_W]),
            .zc      (zc[p]),
            .level   (level),
            .ncyc    (ncyc),
            .cnt_clr (cnt_clr),
            .state   (ph_state[p]),
            .evt     (evt[p])
        );
    end

    sag_regs #(.N(NPH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ph_state  (ph_state),
        .evt_any   (|evt),
        .reg_rdata (reg_rdata),
        .level     (level),
        .ncyc      (ncyc),
        .cnt_clr   (cnt_clr),
        .sts       (sts_q),
        .mask      (mask_q)
    );

    sag_irq u_irq (
        .sts   (sts_q),
        .mask  (mask_q),
        .irq_n (irq_n)
    );
endmodule

// File: rtl/sag_monitor_chk.sv
// Checker for sag_monitor, attached with bind below.
module sag_monitor_chk
    import sag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              irq_n,
    input logic              sts,
    input logic              mask,
    input logic [NPH-1:0]    ph,
    input logic [NPH-1:0]    evt,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata
);
    a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (sts && mask));

    a_r4_event_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> sts);

    a_r7_status_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts) |-> $past(|evt));

    a_r5_state_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != $past(ph)) |-> $past(|evt));

    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STAT && reg_wdata[STS_BIT] && !(|evt)) |=> !sts);
endmodule

bind sag_monitor sag_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_n     (irq_n),
    .sts       (sts_q),
    .mask      (mask_q),
    .ph        (ph_state),
    .evt       (evt),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/sag_monitor_test.sv
module sag_monitor_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  pk_vld = 0;
    logic [71:0] pk_mag = 0;
    logic [2:0]  zc = 0;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq_n;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = !clk;

    sag_monitor uut (.*);

    localparam logic [23:0] LO = 24'd500;
    localparam logic [23:0] HI = 24'd2000;

    // {clr, zc[2:0], low[2:0], exp_ph[2:0], exp_sts}; level 1000, N=3, mask on
    localparam logic [10:0] VEC [11] = '{
        {1'b0, 3'b111, 3'b001, 3'b000, 1'b0},
        {1'b0, 3'b111, 3'b001, 3'b000, 1'b0},
        {1'b0, 3'b111, 3'b011, 3'b001, 1'b1},
        {1'b1, 3'b111, 3'b011, 3'b001, 1'b0},
        {1'b0, 3'b010, 3'b011, 3'b011, 1'b1},
        {1'b1, 3'b111, 3'b010, 3'b011, 1'b0},
        {1'b0, 3'b111, 3'b011, 3'b011, 1'b0},
        {1'b0, 3'b111, 3'b010, 3'b011, 1'b0},
        {1'b0, 3'b111, 3'b010, 3'b011, 1'b0},
        {1'b0, 3'b111, 3'b010, 3'b010, 1'b1},
        {1'b1, 3'b000, 3'b111, 3'b010, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; pk_vld = 0; zc = 0; reg_wr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [71:0] mags(input logic [2:0] low);
        for (int p = 0; p < 3; p++) mags[p*24 +: 24] = low[p] ? LO : HI;
    endfunction

    // One half-cycle step: fresh samples on vld, strobes on z.
    task automatic step(input logic [2:0] z, input logic [2:0] low, input logic [2:0] v);
        @(negedge clk);
        pk_mag = mags(low); pk_vld = v; zc = z;
        @(negedge clk);
        pk_vld = 0; zc = 0;
    endtask

    task automatic chk_ph_sts(input string tag, input logic [2:0] ph, input logic s);
        logic [31:0] d;
        rd(3'd4, d); chk({tag, " phase"}, d, {17'd0, ph, 12'd0});
        rd(3'd3, d); chk({tag, " status"}, d, {15'd0, s, 16'd0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        do_reset();
        // R1 reset state
        chk("R1 irq_n", {31'd0, irq_n}, 1);
        chk_ph_sts("R1", 3'b000, 0);
        rd(3'd0, d); chk("R1 level", d, 0);
        rd(3'd1, d); chk("R1 count", d, 1);
        rd(3'd2, d); chk("R1 mask", d, 0);
        // R2 widths
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d); chk("R2 level width", d, 32'h00FF_FFFF);
        wr(3'd1, 32'hFFFF_FF05);
        rd(3'd1, d); chk("R2 count width", d, 32'h0000_0005);

        // Table walk: R4 R5 R6 R7 R9 R12
        wr(3'd0, 32'd1000); wr(3'd1, 32'd3); wr(3'd2, 32'h0001_0000);
        foreach (VEC[i]) begin
            if (VEC[i][10]) wr(3'd3, 32'h0001_0000);
            step(VEC[i][9:7], VEC[i][6:4], 3'b111);
            chk_ph_sts($sformatf("R4/R5/R6/R12 vec%0d", i), VEC[i][3:1], VEC[i][0]);
            chk($sformatf("R9 vec%0d irq", i), {31'd0, irq_n}, {31'd0, !VEC[i][0]});
        end

        // R3 held sample used when no fresh sample at the strobe
        do_reset();
        wr(3'd0, 32'd1000); wr(3'd1, 32'd1);
        step(3'b000, 3'b001, 3'b001);
        chk_ph_sts("R3 sample only", 3'b000, 0);
        step(3'b001, 3'b000, 3'b000);
        chk_ph_sts("R3 held sample", 3'b001, 1);
        // R7 write with bit 16 clear does nothing
        wr(3'd3, 32'hFFFE_FFFF);
        chk_ph_sts("R7 zero write", 3'b001, 1);
        chk("R9 masked irq", {31'd0, irq_n}, 1);
        // R2 phase-state register is read-only
        wr(3'd4, 32'h0000_0000);
        chk_ph_sts("R2 ro phase", 3'b001, 1);

        // R10 count write restarts runs
        do_reset();
        wr(3'd0, 32'd1000); wr(3'd1, 32'd2); wr(3'd2, 32'h0001_0000);
        step(3'b001, 3'b001, 3'b001);
        wr(3'd1, 32'd2);
        step(3'b001, 3'b001, 3'b001);
        chk_ph_sts("R10 after restart", 3'b000, 0);
        step(3'b001, 3'b001, 3'b001);
        chk_ph_sts("R10 full count", 3'b001, 1);
        chk("R9 irq low", {31'd0, irq_n}, 0);
        wr(3'd3, 32'h0001_0000);
        chk("R9 irq high", {31'd0, irq_n}, 1);

        // R8 set beats clear in the same cycle
        step(3'b001, 3'b000, 3'b001);
        @(negedge clk);
        pk_mag = mags(3'b000); pk_vld = 3'b001; zc = 3'b001;
        reg_wr = 1; reg_addr = 3'd3; reg_wdata = 32'h0001_0000;
        @(negedge clk);
        pk_vld = 0; zc = 0; reg_wr = 0;
        chk_ph_sts("R8 priority", 3'b000, 1);
        chk("R8 irq", {31'd0, irq_n}, 0);
        // R9 masking raises irq_n while status stays
        wr(3'd2, 32'd0);
        chk("R9 mask off irq", {31'd0, irq_n}, 1);

        // R11 count of zero never fires
        wr(3'd3, 32'h0001_0000);
        wr(3'd1, 32'd0);
        for (int k = 0; k < 5; k++) step(3'b111, 3'b111, 3'b111);
        chk_ph_sts("R11 zero count", 3'b000, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule